// File: doc/BRIEF.md
# Receive Queue Descriptor State Tracker

This block keeps the per-queue state that a receive DMA engine and its host share for a set of receive descriptor queues. It holds 16 queues by default. Each queue has a head pointer, a completion pointer, a sticky error flag and an interrupt line. The host starts a queue by writing the address of its first free descriptor into the head pointer. The DMA side reports each descriptor it finishes, and it reports when the queue's chain of free buffers has run out. On exhaustion the block zeroes the head pointer and the queue stops being active.

Each finished descriptor raises the queue interrupt and is remembered as that queue's last completed address. The host acknowledges by writing the completion pointer with the address of the last descriptor it processed. The interrupt drops only when that address equals the last completed address. A write to a head pointer that is already nonzero is refused and flags an error. A head pointer write that is not word aligned is refused in the same way.

Each queue runs two small state machines. The run machine has two states. Q_IDLE means the head pointer is zero. Q_RUN means a descriptor chain is loaded. It moves from Q_IDLE to Q_RUN on a LOAD transition, which is an accepted head pointer write. It moves from Q_RUN back to Q_IDLE on a DRAIN transition, which is the exhaustion signal. The interrupt machine also has two states, I_QUIET and I_PEND. It goes from I_QUIET to I_PEND on a RAISE transition, which is a completed descriptor. It goes from I_PEND back to I_QUIET on an ACK transition, which is a matching completion pointer write in a cycle with no new completion. A completion arriving while already in I_PEND is a REARM: the state stays I_PEND and the recorded address is updated.

Top module: `rxq_desc_tracker`

## Requirements
- R1: After reset every head pointer, completion pointer and error flag reads zero, and every q_active and q_irq bit is low.
- R2: A host write to a queue's head pointer is accepted when the pointer is zero and the data is nonzero with bits 1:0 both zero. From the next cycle the pointer reads back the written value and that queue's q_active bit is high.
- R3: A head pointer write while the current pointer is nonzero is discarded, leaving the old value. It sets that queue's error flag, which reads as bit 0 of the error register.
- R4: A head pointer write whose data has bit 0 or bit 1 set is discarded and sets the same error flag.
- R5: A write to the error register with data bit 0 equal to 1 clears the flag. A write with bit 0 equal to 0 leaves it unchanged.
- R6: An exhaustion pulse for a queue zeroes its head pointer and drops q_active on the next cycle. If a host head pointer write to the same queue arrives in the same cycle, the exhaustion wins and the pointer ends at zero.
- R7: A completion report for a queue records the reported address and sets that queue's q_irq bit on the next cycle.
- R8: A completion pointer write is stored and reads back. It clears q_irq only if its data equals the last recorded completed address. A mismatched value leaves q_irq high.
- R9: When a completion report and a matching completion pointer write reach one queue in the same cycle, q_irq stays high. The newly reported address becomes the one to match.
- R10: A write, completion or exhaustion aimed at one queue changes no state of any other queue.
- R11: The host address is {queue[3:0], select[1:0]}. Select 0 is the head pointer, 1 is the completion pointer, 2 is the error register (only bit 0 is used, the rest read zero) and 3 reads zero. Read data follows the address in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hst_wr_en | input | 1 | Host write strobe |
| hst_addr | input | 6 | Host register address {queue, select} |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data for hst_addr |
| dma_done_vld | input | 1 | A descriptor has been completed |
| dma_done_q | input | 4 | Queue of the completed descriptor |
| dma_done_addr | input | 32 | Address of the completed descriptor |
| dma_exh_vld | input | 1 | Free buffer chain exhausted |
| dma_exh_q | input | 4 | Queue whose chain is exhausted |
| q_active | output | 16 | Per-queue active flag |
| q_irq | output | 16 | Per-queue interrupt |

## Verification
A run machine stuck in the wrong state shows up at the ports one cycle after the event. q_active disagrees with a head pointer read-back, or a refused write is missing from the error flag. A wrong recorded completed address does not appear until the host acknowledges. A matching write then leaves q_irq high, or a mismatched write drops it, on the cycle after that write. For this reason the sweeps pair every completion with both a mismatched and a matching acknowledge, and they check the neighbouring queues after each event.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    typedef enum logic [1:0] {
        SEL_HEAD = 2'd0,
        SEL_COMP = 2'd1,
        SEL_ERR  = 2'd2,
        SEL_NONE = 2'd3
    } rxq_sel_e;

    typedef enum logic {
        Q_IDLE = 1'b0,
        Q_RUN  = 1'b1
    } rxq_run_e;

    typedef enum logic {
        I_QUIET = 1'b0,
        I_PEND  = 1'b1
    } rxq_irq_e;

endpackage

// File: rtl/rxq_host_decode.sv
module rxq_host_decode
    import rxq_pkg::*;
#(
    parameter int NQ = 16,
    parameter int QW = $clog2(NQ)
) (
    input  logic            wr_en,
    input  logic [QW+1:0]   addr,
    output logic [NQ-1:0]   head_we,
    output logic [NQ-1:0]   comp_we,
    output logic [NQ-1:0]   err_we
);

    rxq_sel_e        sel;
    logic [QW-1:0]   qidx;

    assign sel  = rxq_sel_e'(addr[1:0]);
    assign qidx = addr[QW+1:2];

    for (genvar q = 0; q < NQ; q++) begin : g_dec
        logic hit;
        assign hit        = wr_en && (qidx == QW'(q));
        assign head_we[q] = hit && (sel == SEL_HEAD);
        assign comp_we[q] = hit && (sel == SEL_COMP);
        assign err_we[q]  = hit && (sel == SEL_ERR);
    end

endmodule

// File: rtl/rxq_slot.sv
module rxq_slot
    import rxq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          head_we,
    input  logic          comp_we,
    input  logic          err_we,
    input  logic [DW-1:0] wdata,
    input  logic          done_vld,
    input  logic [DW-1:0] done_addr,
    input  logic          exh,
    output logic [DW-1:0] head_ptr,
    output logic [DW-1:0] comp_ptr,
    output logic          err_flag,
    output logic          active,
    output logic          irq
);

    rxq_run_e        run_q, run_d;
    rxq_irq_e        irq_q, irq_d;
    logic [DW-1:0]   head_q, head_d;
    logic [DW-1:0]   comp_q, comp_d;
    logic [DW-1:0]   last_q, last_d;
    logic            err_q, err_d;
    logic            bad_wr;

    // head write refused: pointer busy or address not word aligned
    assign bad_wr = head_we && ((head_q != '0) || (wdata[1:0] != 2'b00));

    // state register process
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q  <= Q_IDLE;
            irq_q  <= I_QUIET;
            head_q <= '0;
            comp_q <= '0;
            last_q <= '0;
            err_q  <= 1'b0;
        end else begin
            run_q  <= run_d;
            irq_q  <= irq_d;
            head_q <= head_d;
            comp_q <= comp_d;
            last_q <= last_d;
            err_q  <= err_d;
        end
    end

    // run machine: LOAD (IDLE->RUN), DRAIN (RUN->IDLE); exhaustion has priority
    always_comb begin
        run_d  = run_q;
        head_d = head_q;
        unique case (run_q)
            Q_IDLE: begin
                if (!exh && head_we && !bad_wr && (wdata != '0)) begin
                    head_d = wdata;
                    run_d  = Q_RUN;
                end
            end
            Q_RUN: begin
                if (exh) begin
                    head_d = '0;
                    run_d  = Q_IDLE;
                end
            end
        endcase
    end

    // error flag: set by a refused write, cleared by write-one
    always_comb begin
        err_d = err_q;
        if (bad_wr)
            err_d = 1'b1;
        else if (err_we && wdata[0])
            err_d = 1'b0;
    end

    // interrupt machine: RAISE, REARM, ACK
    always_comb begin
        irq_d  = irq_q;
        last_d = done_vld ? done_addr : last_q;
        comp_d = comp_we ? wdata : comp_q;
        unique case (irq_q)
            I_QUIET: begin
                if (done_vld)
                    irq_d = I_PEND;
            end
            I_PEND: begin
                if (!done_vld && comp_we && (wdata == last_q))
                    irq_d = I_QUIET;
            end
        endcase
    end

    // output process
    always_comb begin
        head_ptr = head_q;
        comp_ptr = comp_q;
        err_flag = err_q;
        active   = (run_q == Q_RUN);
        irq      = (irq_q == I_PEND);
    end

    p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run_q == Q_IDLE && head_we && wdata != '0 && wdata[1:0] == 2'b00 && !exh)
        |=> (active && head_ptr == $past(wdata)));

    p_busy_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (head_we && head_q != '0 && !exh) |=> ($stable(head_ptr) && err_flag));

    p_misalign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (head_we && wdata[1:0] != 2'b00) |=> err_flag);

    p_drain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exh |=> (head_ptr == '0 && !active));

    p_raise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_vld |=> (irq && last_q == $past(done_addr)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !(comp_we && wdata == last_q)) |=> irq);

endmodule

// File: rtl/rxq_desc_tracker.sv
module rxq_desc_tracker
    import rxq_pkg::*;
#(
    parameter int NQ = 16,
    parameter int DW = 32,
    localparam int QW = $clog2(NQ),
    localparam int AW = QW + 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hst_wr_en,
    input  logic [AW-1:0] hst_addr,
    input  logic [DW-1:0] hst_wdata,
    output logic [DW-1:0] hst_rdata,
    input  logic          dma_done_vld,
    input  logic [QW-1:0] dma_done_q,
    input  logic [DW-1:0] dma_done_addr,
    input  logic          dma_exh_vld,
    input  logic [QW-1:0] dma_exh_q,
    output logic [NQ-1:0] q_active,
    output logic [NQ-1:0] q_irq
);

    logic [NQ-1:0] head_we, comp_we, err_we;
    logic [NQ-1:0] err_vec;
    logic [DW-1:0] head_arr [NQ];
    logic [DW-1:0] comp_arr [NQ];

    rxq_host_decode #(.NQ(NQ), .QW(QW)) u_dec (
        .wr_en   (hst_wr_en),
        .addr    (hst_addr),
        .head_we (head_we),
        .comp_we (comp_we),
        .err_we  (err_we)
    );

    for (genvar q = 0; q < NQ; q++) begin : g_slot
        rxq_slot #(.DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .head_we   (head_we[q]),
            .comp_we   (comp_we[q]),
            .err_we    (err_we[q]),
            .wdata     (hst_wdata),
            .done_vld  (dma_done_vld && (dma_done_q == QW'(q))),
            .done_addr (dma_done_addr),
            .exh       (dma_exh_vld && (dma_exh_q == QW'(q))),
            .head_ptr  (head_arr[q]),
            .comp_ptr  (comp_arr[q]),
            .err_flag  (err_vec[q]),
            .active    (q_active[q]),
            .irq       (q_irq[q])
        );
    end

    // combinational read path
    always_comb begin
        logic [QW-1:0] rq;
        rq        = hst_addr[AW-1:2];
        hst_rdata = '0;
        unique case (rxq_sel_e'(hst_addr[1:0]))
            SEL_HEAD: hst_rdata = head_arr[rq];
            SEL_COMP: hst_rdata = comp_arr[rq];
            SEL_ERR:  hst_rdata = {{(DW-1){1'b0}}, err_vec[rq]};
            SEL_NONE: hst_rdata = '0;
        endcase
    end

    p_done_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_done_vld |=> q_irq[$past(dma_done_q)]);

    p_exh_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dma_exh_vld |=> !q_active[$past(dma_exh_q)]);

endmodule

// File: tb/rxq_desc_tracker_bench.sv
module rxq_desc_tracker_bench;

    localparam int NQ = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_wr_en = 1'b0;
    logic [5:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        dma_done_vld = 1'b0;
    logic [3:0]  dma_done_q = '0;
    logic [31:0] dma_done_addr = '0;
    logic        dma_exh_vld = 1'b0;
    logic [3:0]  dma_exh_q = '0;
    logic [15:0] q_active;
    logic [15:0] q_irq;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    rxq_desc_tracker u_rxq_desc_tracker (
        .clk(clk), .rst_n(rst_n),
        .hst_wr_en(hst_wr_en), .hst_addr(hst_addr),
        .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .dma_done_vld(dma_done_vld), .dma_done_q(dma_done_q),
        .dma_done_addr(dma_done_addr),
        .dma_exh_vld(dma_exh_vld), .dma_exh_q(dma_exh_q),
        .q_active(q_active), .q_irq(q_irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] ra(input int q, input int sel);
        return {4'(q), 2'(sel)};
    endfunction

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        hst_addr = a;
        #1;
        d = hst_rdata;
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        hst_wr_en = 1'b1; hst_addr = a; hst_wdata = d;
        @(negedge clk);
        hst_wr_en = 1'b0;
    endtask

    task automatic done(input int q, input logic [31:0] a);
        dma_done_vld = 1'b1; dma_done_q = 4'(q); dma_done_addr = a;
        @(negedge clk);
        dma_done_vld = 1'b0;
    endtask

    task automatic exhaust(input int q);
        dma_exh_vld = 1'b1; dma_exh_q = 4'(q);
        @(negedge clk);
        dma_exh_vld = 1'b0;
    endtask

    function automatic logic [31:0] hval(input int q);
        return 32'h0001_0000 + (q << 4);
    endfunction

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [31:0] d;
        logic [15:0] mask;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 q_active", {16'b0, q_active}, 32'h0);
        chk("R1 q_irq", {16'b0, q_irq}, 32'h0);
        for (int q = 0; q < NQ; q++) begin
            for (int s = 0; s < 4; s++) begin
                rd(ra(q, s), d);
                chk("R1 reg", d, 32'h0);
            end
        end

        // R2 load every queue, R10 others untouched
        mask = '0;
        for (int q = 0; q < NQ; q++) begin
            wr(ra(q, 0), hval(q));
            mask[q] = 1'b1;
            rd(ra(q, 0), d);
            chk("R2 head readback", d, hval(q));
            chk("R2 R10 active", {16'b0, q_active}, {16'b0, mask});
        end

        // R3 busy write refused, R5 write-one-to-clear, R10 neighbour flag
        for (int q = 0; q < NQ; q++) begin
            wr(ra(q, 0), 32'hDEAD_0000);
            rd(ra(q, 0), d);
            chk("R3 head kept", d, hval(q));
            rd(ra(q, 2), d);
            chk("R3 err set", d, 32'h1);
            rd(ra((q + 1) % NQ, 2), d);
            chk("R10 neighbour err", d, 32'h0);
            wr(ra(q, 2), 32'hFFFF_FFFE);
            rd(ra(q, 2), d);
            chk("R5 bit0 zero keeps", d, 32'h1);
            wr(ra(q, 2), 32'h1);
            rd(ra(q, 2), d);
            chk("R5 cleared", d, 32'h0);
        end

        // R6 exhaustion drains each queue
        mask = 16'hFFFF;
        for (int q = 0; q < NQ; q++) begin
            exhaust(q);
            mask[q] = 1'b0;
            rd(ra(q, 0), d);
            chk("R6 head zero", d, 32'h0);
            chk("R6 R10 active", {16'b0, q_active}, {16'b0, mask});
        end

        // R4 misaligned writes
        for (int q = 0; q < NQ; q++) begin
            for (int lb = 1; lb < 4; lb++) begin
                wr(ra(q, 0), hval(q) | 32'(lb));
                rd(ra(q, 0), d);
                chk("R4 head stays zero", d, 32'h0);
                rd(ra(q, 2), d);
                chk("R4 err set", d, 32'h1);
                chk("R4 not active", {31'b0, q_active[q]}, 32'h0);
                wr(ra(q, 2), 32'h1);
            end
        end

        // R6 exhaustion beats a same-cycle head write
        hst_wr_en = 1'b1; hst_addr = ra(3, 0); hst_wdata = hval(3);
        dma_exh_vld = 1'b1; dma_exh_q = 4'd3;
        @(negedge clk);
        hst_wr_en = 1'b0; dma_exh_vld = 1'b0;
        rd(ra(3, 0), d);
        chk("R6 priority head", d, 32'h0);
        chk("R6 priority active", {31'b0, q_active[3]}, 32'h0);
        rd(ra(3, 2), d);
        chk("R6 priority no err", d, 32'h0);

        // R7 raise, R8 mismatch and match, R10 isolation
        mask = '0;
        for (int q = 0; q < NQ; q++) begin
            logic [31:0] a;
            a = 32'h2000_0000 + (q << 5);
            done(q, a);
            mask[q] = 1'b1;
            chk("R7 R10 irq raised", {16'b0, q_irq}, {16'b0, mask});
            wr(ra(q, 1), a + 32'd4);
            chk("R8 mismatch holds", {31'b0, q_irq[q]}, 32'h1);
            rd(ra(q, 1), d);
            chk("R8 comp readback", d, a + 32'd4);
        end
        for (int q = 0; q < NQ; q++) begin
            wr(ra(q, 1), 32'h2000_0000 + (q << 5));
            mask[q] = 1'b0;
            chk("R8 R10 match clears", {16'b0, q_irq}, {16'b0, mask});
        end

        // R8 only the last completion matches
        done(7, 32'h3000_0000);
        done(7, 32'h3000_0040);
        wr(ra(7, 1), 32'h3000_0000);
        chk("R8 stale ack holds", {31'b0, q_irq[7]}, 32'h1);
        wr(ra(7, 1), 32'h3000_0040);
        chk("R8 latest ack clears", {31'b0, q_irq[7]}, 32'h0);

        // R9 completion and matching ack in one cycle
        done(5, 32'h4000_0000);
        dma_done_vld = 1'b1; dma_done_q = 4'd5; dma_done_addr = 32'h4000_0080;
        hst_wr_en = 1'b1; hst_addr = ra(5, 1); hst_wdata = 32'h4000_0000;
        @(negedge clk);
        dma_done_vld = 1'b0; hst_wr_en = 1'b0;
        chk("R9 irq stays", {31'b0, q_irq[5]}, 32'h1);
        wr(ra(5, 1), 32'h4000_0080);
        chk("R9 new address clears", {31'b0, q_irq[5]}, 32'h0);

        // R11 error register upper bits and select 3
        wr(ra(9, 0), 32'h5);
        rd(ra(9, 2), d);
        chk("R11 err reg format", d, 32'h1);
        rd(ra(9, 3), d);
        chk("R11 select 3 zero", d, 32'h0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule